// File: doc/BRIEF.md
# Status Register and Write-Protect Guard

This block keeps the eight-bit status byte of a serial memory and decides, at the end of each chip-select session, whether a requested write to the memory array or to the status byte itself may go ahead. The command decoder upstream hands it one-cycle events for write-enable, write-disable, status-write (with its data byte) and array-write (with the page start address). The block holds the first such event of a session. When chip select returns high it either issues a one-cycle grant or refuses the write silently. The write-cycle timer that follows reports its busy state back, and that state appears as the ready/busy bit.

Hardware protection combines the write-protect pin with a protect-enable bit held in the status byte. Two block-protect bits lock the top quarter, the top half or the whole array. A power-on reset clears everything. A soft reset clears only the volatile write-enable bit, so the protect-enable and block-protect bits behave like non-volatile cells.

Top module: `wp_status_guard`

## Requirements
- R1: After power-on reset (`rst_n` low) the status byte reads 0x00 while `busy_i` is low.
- R2: The status byte carries protect-enable at bit 7, block-protect high at bit 3, block-protect low at bit 2, write-enable at bit 1 and `busy_i` at bit 0; bits 6 to 4 always read 0.
- R3: A write-enable event sets the write-enable bit and a write-disable event clears it, only once chip select has returned high; during the session the bit keeps its old value.
- R4: A granted status write copies data bits 7, 3 and 2 into the status byte; all other data bits have no effect.
- R5: Block-protect code 00 locks nothing, 01 locks addresses 0xC00 to 0xFFF, 10 locks 0x800 to 0xFFF and 11 locks the whole array (default 12-bit address).
- R6: An array write is granted only if write-enable is 1 and its start address is unlocked; a locked start address refuses the whole page and no grant is issued.
- R7: A status write is granted only if write-enable is 1 and not (protect-enable is 1 and `wp_n_i` is low).
- R8: If `wp_n_i` is low at any cycle of a selected status-write session while protect-enable is 1, that write is cancelled even if the pin rises again; after a grant the pin no longer changes the written bits.
- R9: While `busy_i` is high, all four write-related events are ignored and no grant is issued.
- R10: When `busy_i` falls, the write-enable bit is cleared in the next cycle.
- R11: A soft reset clears write-enable and leaves protect-enable and block-protect unchanged.
- R12: A grant is a single-cycle pulse, issued in the cycle after the clock edge that first samples chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, clears all state |
| soft_rst_i | input | 1 | Soft reset, clears volatile state only |
| cs_n_i | input | 1 | Chip select, active low |
| wp_n_i | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Internal write cycle in progress |
| wren_i | input | 1 | Write-enable command event |
| wrdi_i | input | 1 | Write-disable command event |
| wrsr_i | input | 1 | Status-write command event with data |
| wrsr_data_i | input | 8 | Data byte of a status write |
| mem_wr_i | input | 1 | Array-write command event with address |
| mem_addr_i | input | AW | Start address of the array write |
| status_o | output | 8 | Status byte for a status read |
| grant_mem_o | output | 1 | Array write granted, one cycle |
| grant_sr_o | output | 1 | Status write granted, one cycle |

## Verification
A wrong block-protect or protect-enable bit shows on `status_o` in the cycle after the grant that loaded it. It also changes the grant decision of every later array or status write. A write-enable bit stuck or set too early shows on bit 1 before chip select rises. Such a bit also yields a grant where a refusal was due, one cycle after the rising chip select. The sweep crosses all block-protect codes, both protect-enable and pin values and both write-enable states with addresses on each side of every range limit, so a misplaced limit shows in the first session that straddles it.

// File: rtl/wps_pkg.sv
package wps_pkg;

  localparam int SR_WPEN = 7;
  localparam int SR_BPH  = 3;
  localparam int SR_BPL  = 2;
  localparam int SR_WEL  = 1;
  localparam int SR_RDY  = 0;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_WREN  = 3'd1,
    CMD_WRDI  = 3'd2,
    CMD_WRSR  = 3'd3,
    CMD_MEMWR = 3'd4
  } wps_cmd_e;

  // Top two address bits decide the lock for every block-protect code.
  function automatic logic blk_locked(input logic [1:0] bp, input logic [1:0] top);
    logic r;
    case (bp)
      2'b00:   r = 1'b0;
      2'b01:   r = (top == 2'b11);
      2'b10:   r = top[1];
      default: r = 1'b1;
    endcase
    return r;
  endfunction

  function automatic logic sr_locked(input logic wpen, input logic wp_n);
    return wpen & ~wp_n;
  endfunction

  function automatic logic [7:0] sr_pack(input logic wpen, input logic [1:0] bp,
                                         input logic wel, input logic rdy);
    logic [7:0] s;
    s = '0;
    s[SR_WPEN] = wpen;
    s[SR_BPH]  = bp[1];
    s[SR_BPL]  = bp[0];
    s[SR_WEL]  = wel;
    s[SR_RDY]  = rdy;
    return s;
  endfunction

endpackage

// File: rtl/wps_cmd_capture.sv
module wps_cmd_capture
  import wps_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          cs_n,
  input  logic          busy,
  input  logic          ev_wren,
  input  logic          ev_wrdi,
  input  logic          ev_wrsr,
  input  logic [7:0]    sr_data,
  input  logic          ev_mem,
  input  logic [AW-1:0] mem_addr,
  input  logic          wp_n,
  input  logic          wpen,
  output wps_cmd_e      cmd_q,
  output logic [7:0]    sr_data_q,
  output logic [1:0]    addr_top_q,
  output logic          sr_cancel_q,
  output logic          cs_rise
);

  logic     cs_n_q;
  logic     take;
  wps_cmd_e cmd_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n_q <= 1'b1;
    else        cs_n_q <= cs_n;
  end

  assign cs_rise = !cs_n_q && cs_n;
  assign take    = !cs_n && !busy && !soft_rst && (cmd_q == CMD_NONE);

  always_comb begin
    if (ev_wren)      cmd_nx = CMD_WREN;
    else if (ev_wrdi) cmd_nx = CMD_WRDI;
    else if (ev_wrsr) cmd_nx = CMD_WRSR;
    else if (ev_mem)  cmd_nx = CMD_MEMWR;
    else              cmd_nx = CMD_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q       <= CMD_NONE;
      sr_data_q   <= '0;
      addr_top_q  <= '0;
      sr_cancel_q <= 1'b0;
    end else if (soft_rst || cs_n) begin
      cmd_q       <= CMD_NONE;
      sr_cancel_q <= 1'b0;
    end else if (take && (cmd_nx != CMD_NONE)) begin
      cmd_q       <= cmd_nx;
      sr_data_q   <= sr_data;
      addr_top_q  <= mem_addr[AW-1 -: 2];
      sr_cancel_q <= 1'b0;
    end else if ((cmd_q == CMD_WRSR) && sr_locked(wpen, wp_n)) begin
      sr_cancel_q <= 1'b1;
    end
  end

endmodule

// File: rtl/wps_status_regs.sv
module wps_status_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       busy,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       sr_load,
  input  logic [7:0] sr_data,
  output logic       wpen,
  output logic [1:0] bp,
  output logic       wel,
  output logic       cycle_done
);
  import wps_pkg::*;

  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy;
  end

  assign cycle_done = busy_q && !busy;

  // Protect bits: only power-on reset clears them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpen <= 1'b0;
      bp   <= 2'b00;
    end else if (sr_load) begin
      wpen <= sr_data[SR_WPEN];
      bp   <= {sr_data[SR_BPH], sr_data[SR_BPL]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       wel <= 1'b0;
    else if (soft_rst || cycle_done) wel <= 1'b0;
    else if (set_wel)                wel <= 1'b1;
    else if (clr_wel)                wel <= 1'b0;
  end

endmodule

// File: rtl/wps_grant_logic.sv
module wps_grant_logic
  import wps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  wps_cmd_e   cmd,
  input  logic       cs_rise,
  input  logic       busy,
  input  logic       wel,
  input  logic       wpen,
  input  logic [1:0] bp,
  input  logic       wp_n,
  input  logic       sr_cancel,
  input  logic [1:0] addr_top,
  output logic       set_wel,
  output logic       clr_wel,
  output logic       sr_load,
  output logic       grant_mem_q,
  output logic       grant_sr_q
);

  logic fire;
  logic mem_ok;

  assign fire    = cs_rise && !busy && !soft_rst;
  assign set_wel = fire && (cmd == CMD_WREN);
  assign clr_wel = fire && (cmd == CMD_WRDI);
  assign mem_ok  = fire && (cmd == CMD_MEMWR) && wel && !blk_locked(bp, addr_top);
  assign sr_load = fire && (cmd == CMD_WRSR) && wel && !sr_cancel && !sr_locked(wpen, wp_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_mem_q <= 1'b0;
      grant_sr_q  <= 1'b0;
    end else begin
      grant_mem_q <= mem_ok;
      grant_sr_q  <= sr_load;
    end
  end

endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
  import wps_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst_i,
  input  logic          cs_n_i,
  input  logic          wp_n_i,
  input  logic          busy_i,
  input  logic          wren_i,
  input  logic          wrdi_i,
  input  logic          wrsr_i,
  input  logic [7:0]    wrsr_data_i,
  input  logic          mem_wr_i,
  input  logic [AW-1:0] mem_addr_i,
  output logic [7:0]    status_o,
  output logic          grant_mem_o,
  output logic          grant_sr_o
);

  wps_cmd_e   cmd_q;
  logic [7:0] sr_data_q;
  logic [1:0] addr_top_q;
  logic       sr_cancel_q;
  logic       cs_rise;
  logic       set_wel, clr_wel, sr_load;
  logic       wpen, wel, cycle_done;
  logic [1:0] bp;

  wps_cmd_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i), .cs_n(cs_n_i), .busy(busy_i),
    .ev_wren(wren_i), .ev_wrdi(wrdi_i), .ev_wrsr(wrsr_i), .sr_data(wrsr_data_i),
    .ev_mem(mem_wr_i), .mem_addr(mem_addr_i), .wp_n(wp_n_i), .wpen(wpen),
    .cmd_q(cmd_q), .sr_data_q(sr_data_q), .addr_top_q(addr_top_q),
    .sr_cancel_q(sr_cancel_q), .cs_rise(cs_rise)
  );

  wps_grant_logic u_grant (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i), .cmd(cmd_q), .cs_rise(cs_rise),
    .busy(busy_i), .wel(wel), .wpen(wpen), .bp(bp), .wp_n(wp_n_i),
    .sr_cancel(sr_cancel_q), .addr_top(addr_top_q),
    .set_wel(set_wel), .clr_wel(clr_wel), .sr_load(sr_load),
    .grant_mem_q(grant_mem_o), .grant_sr_q(grant_sr_o)
  );

  wps_status_regs u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i), .busy(busy_i),
    .set_wel(set_wel), .clr_wel(clr_wel), .sr_load(sr_load), .sr_data(sr_data_q),
    .wpen(wpen), .bp(bp), .wel(wel), .cycle_done(cycle_done)
  );

  assign status_o = sr_pack(wpen, bp, wel, busy_i);

endmodule

// File: rtl/wps_checker.sv
module wps_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst_i,
  input logic       busy_i,
  input logic       wp_n_i,
  input logic [7:0] status_o,
  input logic       grant_mem_o,
  input logic       grant_sr_o,
  input logic       cs_rise,
  input logic       sr_cancel_q
);

  assert_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:4] == 3'b000);

  assert_wel_on_cs_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> $past(cs_rise));

  assert_mem_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_mem_o |-> $past(status_o[1]));

  assert_sr_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_sr_o |-> ($past(status_o[1]) && !($past(status_o[7]) && !$past(wp_n_i))));

  assert_cancel_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && sr_cancel_q) |=> !grant_sr_o);

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (!grant_mem_o && !grant_sr_o));

  assert_wel_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_i) |=> !status_o[1]);

  assert_soft_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!status_o[1] && $stable(status_o[7:2])));

  assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_mem_o || grant_sr_o) |=> (!grant_mem_o && !grant_sr_o));

  assert_one_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_mem_o && grant_sr_o));

endmodule

bind wp_status_guard wps_checker u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .busy_i(busy_i), .wp_n_i(wp_n_i),
  .status_o(status_o), .grant_mem_o(grant_mem_o), .grant_sr_o(grant_sr_o),
  .cs_rise(cs_rise), .sr_cancel_q(sr_cancel_q)
);

// File: tb/wp_status_guard_tb.sv
module wp_status_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        cs_n_i = 1'b1;
  logic        wp_n_i = 1'b1;
  logic        busy_i = 1'b0;
  logic        wren_i = 1'b0, wrdi_i = 1'b0, wrsr_i = 1'b0, mem_wr_i = 1'b0;
  logic [7:0]  wrsr_data_i = '0;
  logic [11:0] mem_addr_i = '0;
  logic [7:0]  status_o;
  logic        grant_mem_o, grant_sr_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] pre_status;
  bit gm, gs;

  localparam int K_WREN = 1, K_WRDI = 2, K_WRSR = 3, K_MEM = 4;

  always #2 clk = ~clk;

  wp_status_guard #(.AW(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i), .cs_n_i(cs_n_i), .wp_n_i(wp_n_i),
    .busy_i(busy_i), .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_i(wrsr_i),
    .wrsr_data_i(wrsr_data_i), .mem_wr_i(mem_wr_i), .mem_addr_i(mem_addr_i),
    .status_o(status_o), .grant_mem_o(grant_mem_o), .grant_sr_o(grant_sr_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_sr(input bit wpen, input int bp, input bit wel, input bit rdy);
    return {wpen, 3'b000, 2'(bp), wel, rdy};
  endfunction

  function automatic int lock_base(input int bp);
    return (bp == 0) ? 4096 : (bp == 1) ? 3072 : (bp == 2) ? 2048 : 0;
  endfunction

  function automatic logic [11:0] pick_addr(input int k);
    case (k)
      0: return 12'h000;
      1: return 12'h7FF;
      2: return 12'h800;
      3: return 12'hBFF;
      4: return 12'hC00;
      5: return 12'hFFF;
      6: return 12'h3A5;
      default: return 12'hD12;
    endcase
  endfunction

  task automatic sess(input int kind, input logic [7:0] d, input logic [11:0] a, input bit glitch);
    @(negedge clk) cs_n_i = 1'b0;
    @(negedge clk);
    wren_i = (kind == K_WREN); wrdi_i = (kind == K_WRDI);
    wrsr_i = (kind == K_WRSR); mem_wr_i = (kind == K_MEM);
    wrsr_data_i = d; mem_addr_i = a;
    @(negedge clk);
    wren_i = 1'b0; wrdi_i = 1'b0; wrsr_i = 1'b0; mem_wr_i = 1'b0;
    if (glitch) begin
      wp_n_i = 1'b0;
      @(negedge clk) wp_n_i = 1'b1;
    end
    pre_status = status_o;
    @(negedge clk) cs_n_i = 1'b1;
    @(negedge clk);
    gm = grant_mem_o; gs = grant_sr_o;
    @(negedge clk);
    chk(!grant_mem_o && !grant_sr_o, "R12 grant lasts one cycle",
        {grant_mem_o, grant_sr_o}, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit wl_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status_o == 8'h00, "R1 reset status", status_o, 0);

    // Sweep: block-protect x protect-enable x pin x write-enable x address
    for (int bp = 0; bp < 4; bp++) begin
      for (int we = 0; we < 2; we++) begin
        wp_n_i = 1'b1;
        sess(K_WREN, 8'h00, 12'h0, 1'b0);
        sess(K_WRSR, {we[0], 3'b000, 2'(bp), 2'b00}, 12'h0, 1'b0);
        chk(gs == 1'b1, "R7 config status write", gs, 1);
        chk(status_o == model_sr(we[0], bp, 1'b1, 1'b0), "R4 status after load",
            status_o, model_sr(we[0], bp, 1'b1, 1'b0));
        for (int wp = 0; wp < 2; wp++) begin
          for (int wl = 0; wl < 2; wl++) begin
            wp_n_i = wp[0];
            sess(wl ? K_WREN : K_WRDI, 8'h00, 12'h0, 1'b0);
            chk(status_o == model_sr(we[0], bp, wl[0], 1'b0), "R2 status layout",
                status_o, model_sr(we[0], bp, wl[0], 1'b0));
            for (int k = 0; k < 8; k++) begin
              sess(K_MEM, 8'h00, pick_addr(k), 1'b0);
              wl_exp = wl[0] && !(int'(pick_addr(k)) >= lock_base(bp));
              chk(gm == wl_exp, "R5 R6 array grant", gm, wl_exp);
            end
            sess(K_WRSR, {we[0], 3'b000, 2'(bp), 2'b00}, 12'h0, 1'b0);
            wl_exp = wl[0] && !(we[0] && !wp[0]);
            chk(gs == wl_exp, "R7 status grant", gs, wl_exp);
          end
        end
      end
    end

    // Power-on reset clears protect bits as well
    wp_n_i = 1'b1;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(status_o == 8'h00, "R1 status after second reset", status_o, 0);

    // R3: bit unchanged within session, set after rise
    sess(K_WREN, 8'h00, 12'h0, 1'b0);
    chk(pre_status[1] == 1'b0, "R3 WEL before cs rise", pre_status[1], 0);
    chk(status_o == 8'h02, "R3 WEL after cs rise", status_o, 8'h02);

    // R4: only bits 7, 3, 2 are written
    sess(K_WRSR, 8'hFF, 12'h0, 1'b0);
    chk(status_o == 8'h8E, "R4 masked status write", status_o, 8'h8E);

    // R8: pin glitch during selected session cancels
    sess(K_WRSR, 8'h00, 12'h0, 1'b1);
    chk(gs == 1'b0, "R8 cancelled grant", gs, 0);
    chk(status_o == 8'h8E, "R8 status unchanged", status_o, 8'h8E);
    sess(K_WRSR, 8'h80, 12'h0, 1'b0);
    chk(gs == 1'b1, "R8 clean status write", gs, 1);
    @(negedge clk) wp_n_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(status_o == 8'h82, "R8 pin after grant no effect", status_o, 8'h82);
    wp_n_i = 1'b1;

    // R9: events ignored while busy, R10: WEL drops at end of cycle
    @(negedge clk) busy_i = 1'b1;
    @(negedge clk);
    chk(status_o == 8'h83, "R2 busy bit", status_o, 8'h83);
    sess(K_WRDI, 8'h00, 12'h0, 1'b0);
    chk(status_o == 8'h83, "R9 WRDI ignored while busy", status_o, 8'h83);
    sess(K_MEM, 8'h00, 12'h000, 1'b0);
    chk(gm == 1'b0, "R9 array write ignored while busy", gm, 0);
    busy_i = 1'b0;
    @(negedge clk);
    chk(status_o == 8'h80, "R10 WEL cleared at cycle end", status_o, 8'h80);

    // R11: soft reset keeps protect bits
    sess(K_WREN, 8'h00, 12'h0, 1'b0);
    sess(K_WRSR, 8'h88, 12'h0, 1'b0);
    chk(status_o == 8'h8A, "R11 setup", status_o, 8'h8A);
    @(negedge clk) soft_rst_i = 1'b1;
    @(negedge clk) soft_rst_i = 1'b0;
    chk(status_o == 8'h88, "R11 soft reset", status_o, 8'h88);
    sess(K_MEM, 8'h00, 12'h100, 1'b0);
    chk(gm == 1'b0, "R11 R6 no grant after soft reset", gm, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule